// File: doc/BRIEF.md
# Complex-Baseband AM/FM Demodulator

This block takes a stream of already-decimated complex baseband samples, each a signed 12-bit in-phase and quadrature pair qualified by a valid strobe. Before any demodulation it removes residual carrier and DC from both channels with a first-order high-pass recursion. From the filtered pair it produces two results. The envelope result is the squared magnitude of the current sample. The frequency result is the cross-product of the current and previous samples, normalised by that same squared magnitude.

The normalising division is done bit-serially, which is possible because the sample rate after decimation is far below the clock rate. While the divider is running the block lowers its ready output, and it drops any sample offered during that time. When the squared magnitude is too small to divide by safely, the frequency result is forced to zero and no division is started. The first sample after reset has no predecessor, so it yields an envelope result and no frequency result.

Top module: `iq_demod`

## Requirements
- R1: After reset, am_valid and fm_valid are low, in_ready is high, and am_out and fm_out are zero.
- R2: Each channel is high-passed as acc(n) = 256·(x(n) − x(n−1)) + acc(n−1) − floor(acc(n−1)/256), starting from acc = 0 and x = 0. The filtered value y(n) is floor(acc(n)/256), clamped to [−2048, 2047]. The filter state advances only on accepted samples.
- R3: A sample is accepted on a rising clock edge where in_valid and in_ready are both high. On the next cycle, am_valid is high for exactly one cycle and am_out (25-bit unsigned) equals yi² + yq² of that sample.
- R4: For an accepted sample that has a predecessor and whose squared magnitude is at least 16, fm_out is produced 38 clock edges after the accept edge, with fm_valid high for one cycle. fm_out equals sign(c)·floor(|c|·2^14 / m), where c = yq(n)·yi(n−1) − yi(n)·yq(n−1) and m = yi(n)² + yq(n)².
- R5: The first sample accepted after reset produces no fm_valid pulse.
- R6: When the squared magnitude is below 16 and a predecessor exists, fm_valid rises in the same cycle as am_valid with fm_out = 0, and in_ready stays high.
- R7: in_ready is low from the cycle after a division starts until the cycle in which fm_valid rises. A sample offered while in_ready is low is dropped: it produces no am_valid pulse and changes no state.
- R8: The stored previous filtered sample is updated only by accepted samples.
- R9: fm_out saturates to 32767 for large positive quotients and to −32768 for large negative ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 12 | In-phase sample, signed |
| in_q | input | 12 | Quadrature sample, signed |
| in_ready | output | 1 | High when a sample can be accepted |
| am_valid | output | 1 | Envelope result strobe |
| am_out | output | 25 | Squared magnitude, unsigned |
| fm_valid | output | 1 | Frequency result strobe |
| fm_out | output | 16 | Normalised cross-product, signed, 14 fractional bits |

## Verification
The envelope result is due one cycle after the accept edge, so the bench reads it at the first falling edge after that edge. A guarded zero frequency result is due in that same cycle. A divided frequency result is due 38 edges after acceptance. The bench counts falling edges from the envelope check until fm_valid rises and compares that count with 38, then compares the value. A sample injected while the divider is busy must leave no envelope pulse during the wait. It must also leave the next accepted sample's results exactly as the model predicts without it.

// File: rtl/iq_demod.sv
module iq_demod #(
  parameter int DW      = 12,
  parameter int SH      = 8,
  parameter int FRAC    = 14,
  parameter int QW      = 16,
  parameter int MAG_MIN = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 in_ready,
  output logic                 am_valid,
  output logic [2*DW:0]        am_out,
  output logic                 fm_valid,
  output logic [QW-1:0]        fm_out
);
  localparam int ACCW = DW + 2*SH + 4;
  localparam int MW   = 2*DW + 1;
  localparam int NUMW = 2*DW + FRAC;
  localparam int CW   = $clog2(NUMW + 1);
  localparam logic signed [ACCW-1:0] YMAX = ACCW'((1 << (DW-1)) - 1);
  localparam logic signed [ACCW-1:0] YMIN = -YMAX - 1;
  localparam logic [NUMW-1:0] QMAX = NUMW'((1 << (QW-1)) - 1);

  function automatic logic signed [ACCW-1:0] dc_step(
    input logic signed [ACCW-1:0] acc,
    input logic signed [DW-1:0]   x,
    input logic signed [DW-1:0]   xp);
    logic signed [ACCW-1:0] d;
    d = ACCW'(x) - ACCW'(xp);
    return (d <<< SH) + acc - (acc >>> SH);
  endfunction

  function automatic logic signed [DW-1:0] dc_out(input logic signed [ACCW-1:0] acc);
    logic signed [ACCW-1:0] t;
    t = acc >>> SH;
    if (t > YMAX) t = YMAX;
    if (t < YMIN) t = YMIN;
    return DW'(t);
  endfunction

  logic signed [ACCW-1:0] acc_i, acc_q, acc_i_n, acc_q_n;
  logic signed [DW-1:0]   xp_i, xp_q, yi, yq, ip, qp;
  logic                   have_prev, busy, neg;
  logic [CW-1:0]          cnt;
  logic [MW-1:0]          rem, rem_n;
  logic [MW:0]            rem_sh;
  logic [NUMW-1:0]        num, num_n;
  logic                   ge;
  logic signed [MW-1:0]   yi_w, yq_w, ip_w, qp_w, cross_n, abs_n;
  logic [MW-1:0]          mag_n;
  logic [QW-1:0]          fm_sat;
  logic                   accept;

  assign acc_i_n = dc_step(acc_i, in_i, xp_i);
  assign acc_q_n = dc_step(acc_q, in_q, xp_q);
  assign yi      = dc_out(acc_i_n);
  assign yq      = dc_out(acc_q_n);
  assign yi_w    = MW'(yi);
  assign yq_w    = MW'(yq);
  assign ip_w    = MW'(ip);
  assign qp_w    = MW'(qp);
  assign mag_n   = $unsigned(yi_w * yi_w + yq_w * yq_w);
  assign cross_n = yq_w * ip_w - yi_w * qp_w;
  assign abs_n   = cross_n[MW-1] ? -cross_n : cross_n;

  assign in_ready = !busy;
  assign accept   = in_valid && !busy;

  assign rem_sh = {rem, num[NUMW-1]};
  assign ge     = rem_sh >= {1'b0, am_out};
  assign rem_n  = ge ? MW'(rem_sh - {1'b0, am_out}) : MW'(rem_sh);
  assign num_n  = {num[NUMW-2:0], ge};

  always_comb begin
    if (!neg) fm_sat = (num_n > QMAX) ? QW'(QMAX) : num_n[QW-1:0];
    else if (num_n > QMAX + 1'b1) fm_sat = {1'b1, {(QW-1){1'b0}}};
    else fm_sat = -num_n[QW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_i <= '0; acc_q <= '0; xp_i <= '0; xp_q <= '0;
      ip <= '0; qp <= '0; have_prev <= 1'b0;
      busy <= 1'b0; neg <= 1'b0; cnt <= '0; rem <= '0; num <= '0;
      am_valid <= 1'b0; am_out <= '0; fm_valid <= 1'b0; fm_out <= '0;
    end else begin
      am_valid <= 1'b0;
      fm_valid <= 1'b0;
      if (accept) begin
        acc_i <= acc_i_n; acc_q <= acc_q_n;
        xp_i <= in_i; xp_q <= in_q;
        ip <= yi; qp <= yq;
        have_prev <= 1'b1;
        am_out <= mag_n;
        am_valid <= 1'b1;
        if (have_prev) begin
          if (mag_n < MW'(MAG_MIN)) begin
            fm_out <= '0;
            fm_valid <= 1'b1;
          end else begin
            busy <= 1'b1;
            cnt <= CW'(NUMW);
            rem <= '0;
            num <= {abs_n[2*DW-1:0], {FRAC{1'b0}}};
            neg <= cross_n[MW-1];
          end
        end
      end else if (busy) begin
        rem <= rem_n;
        num <= num_n;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          fm_valid <= 1'b1;
          fm_out <= fm_sat;
        end
      end
    end
  end

  assert_no_result_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> !am_valid);
  assert_divisor_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(am_out));
  assert_ready_at_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fm_valid |-> in_ready);
  assert_guard_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fm_valid && am_valid) |-> (fm_out == '0));
  assert_busy_starts_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> am_valid);
endmodule

// File: tb/iq_demod_tb.sv
module iq_demod_tb;
  localparam int LAT = 38;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [11:0] in_i = '0, in_q = '0;
  logic in_ready, am_valid, fm_valid;
  logic [24:0] am_out;
  logic [15:0] fm_out;
  int total = 0, bad = 0;

  longint acc_i, acc_q, xp_i, xp_q, pi_m, pq_m;
  bit havep;

  localparam int NV = 10;
  localparam int VI [NV] = '{1000, 707, 0, -707, -1000, 300, -2048, 2047, 5, -400};
  localparam int VQ [NV] = '{0, 707, 1000, 707, 0, -1200, 2047, -2048, 3, -900};

  iq_demod u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .in_ready(in_ready), .am_valid(am_valid), .am_out(am_out), .fm_valid(fm_valid), .fm_out(fm_out));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint clamp12(input longint v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  task automatic model_reset();
    acc_i = 0; acc_q = 0; xp_i = 0; xp_q = 0; pi_m = 0; pq_m = 0; havep = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; in_valid = 0;
    repeat (2) @(negedge clk);
    chk(am_valid == 0 && fm_valid == 0, "R1 valids low", {am_valid, fm_valid}, 0);
    chk(in_ready == 1, "R1 ready high", in_ready, 1);
    chk(am_out == 0 && fm_out == 0, "R1 outputs zero", am_out, 0);
    rst_n = 1;
    model_reset();
  endtask

  task automatic send(input int xi, input int xq, input int inj, input string tg);
    longint yi, yq, mag, cr, qm, efm;
    int n;
    bit had, amseen;
    @(negedge clk);
    chk(in_ready == 1, {"R7 ready before send ", tg}, in_ready, 1);
    in_valid = 1; in_i = 12'(xi); in_q = 12'(xq);
    @(negedge clk);
    in_valid = 0;
    acc_i = (longint'(xi) - xp_i) * 256 + acc_i - (acc_i >>> 8);
    acc_q = (longint'(xq) - xp_q) * 256 + acc_q - (acc_q >>> 8);
    xp_i = xi; xp_q = xq;
    yi = clamp12(acc_i >>> 8); yq = clamp12(acc_q >>> 8);
    mag = yi * yi + yq * yq;
    cr = yq * pi_m - yi * pq_m;
    had = havep;
    pi_m = yi; pq_m = yq; havep = 1;
    chk(am_valid == 1, {"R3 am_valid ", tg}, am_valid, 1);
    chk(am_out == mag, {"R2 R3 am_out ", tg}, am_out, mag);
    if (!had) begin
      chk(fm_valid == 0, {"R5 no fm on first sample ", tg}, fm_valid, 0);
      @(negedge clk);
      chk(fm_valid == 0 && in_ready == 1, {"R5 still no fm ", tg}, fm_valid, 0);
    end else if (mag < 16) begin
      chk(fm_valid == 1 && fm_out == 0, {"R6 guarded zero ", tg}, fm_out, 0);
      chk(in_ready == 1, {"R6 no divide ", tg}, in_ready, 1);
    end else begin
      qm = ((cr < 0 ? -cr : cr) << 14) / mag;
      if (cr < 0) efm = (qm > 32768) ? -32768 : -qm;
      else efm = (qm > 32767) ? 32767 : qm;
      chk(fm_valid == 0 && in_ready == 0, {"R7 busy after start ", tg}, in_ready, 0);
      n = 0; amseen = 0;
      while (!fm_valid && n < 100) begin
        if (n == inj && inj > 0) begin
          in_valid = 1; in_i = 12'sd1500; in_q = -12'sd1500;
        end
        @(negedge clk);
        in_valid = 0;
        n++;
        if (am_valid) amseen = 1;
        if (!fm_valid && in_ready) amseen = 1;
      end
      chk(n == LAT, {"R4 fm latency ", tg}, n, LAT);
      chk($signed(fm_out) == efm, {"R4 R9 fm_out ", tg}, longint'($signed(fm_out)), efm);
      if (inj > 0) chk(amseen == 0, {"R7 busy sample dropped ", tg}, amseen, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    for (int k = 0; k < NV; k++) send(VI[k], VQ[k], 0, "table");
    send(600, -300, 10, "R7 inject");
    send(-250, 800, 0, "R8 prev kept after drop");
    do_reset();
    send(0, 0, 0, "R5 first");
    send(2, 1, 0, "R6 small");
    send(2, 1, 0, "R6 smaller");
    do_reset();
    send(2000, 0, 0, "R9 setup pos");
    send(10, 5, 0, "R9 positive saturation");
    do_reset();
    send(2000, 0, 0, "R9 setup neg");
    send(10, -5, 0, "R9 negative saturation");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule